// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the 32-bit program counter of a single-cycle processor core and picks its value for the next cycle. On every rising clock edge it loads one of three candidate addresses: the next sequential word, a branch target relative to the following instruction, or a pseudo-direct jump target. The pseudo-direct target keeps the upper region bits of the following instruction's address and fills the rest from the instruction's 26-bit field.

The current counter drives the instruction memory address. The incremented value is also offered to the rest of the core. Decode logic supplies the 16-bit immediate, the 26-bit jump field and the branch and jump flags. The ALU supplies its zero flag.

Top module: `nextpc_unit`

## Requirements
- R1: Reset is synchronous and active-high. A rising edge with `rst` high loads 0x0000_0000, whatever the other inputs are.
- R2: With `rst`, `jump_i` and `branch_i` low, each rising edge adds 4 to the counter.
- R3: `pc_plus4_o` always equals `pc_o` + 4, modulo 2^32.
- R4: With `branch_i` and `zero_i` high and `jump_i` low, the next counter is (`pc_o` + 4) + (sign-extended `imm_i` × 4). Bit 15 of `imm_i` is the sign bit.
- R5: With `branch_i` high and `zero_i` low, and `jump_i` low, the branch is not taken and the counter advances by 4. A high `zero_i` without `branch_i` also has no effect.
- R6: With `jump_i` high, the next counter is {(`pc_o` + 4)[31:28], `target_i`[25:0], 2'b00}. The region bits come from the incremented address, so a jump placed in the last word of a 256 MB region lands in the following region.
- R7: A high `jump_i` takes priority over a taken branch.
- R8: Bits [1:0] of `pc_o` are always zero after reset.
- R9: Address arithmetic wraps modulo 2^32: the sequential step from 0xFFFF_FFFC gives 0x0000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imm_i | input | 16 | Branch offset in words, two's complement |
| target_i | input | 26 | Word index of the jump target inside the current region |
| branch_i | input | 1 | Current instruction is a conditional branch |
| jump_i | input | 1 | Current instruction is a pseudo-direct jump |
| zero_i | input | 1 | ALU result was zero |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current program counter plus 4 |

## Verification
The branch offset is swept across the whole 16-bit range in even steps, with both signs. This separates correct sign extension and the two-bit shift from a wrong base (the raw counter instead of counter + 4). Every combination of the branch, zero and jump flags is applied with a fixed immediate and target. This shows the taken condition needs both branch and zero, and that jump wins over branch. A chain of jumps to the last word of each 256 MB region moves the counter across every region boundary up to 0xFFFF_FFFC. That tells apart region bits taken from counter + 4 and those taken from the raw counter. A final sequential step then shows the wrap to zero. Reset is asserted with every select flag high to show that reset wins.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Source of the value loaded into the program counter
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2,
        SRC_RESET  = 2'd3
    } npc_src_e;

endpackage

// File: rtl/npc_seq_adder.sv
module npc_seq_adder #(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 2
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_next_seq
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

    // Modulo-2^ADDR_W increment by one instruction word
    assign pc_next_seq = pc + STEP;

endmodule

// File: rtl/npc_branch_calc.sv
module npc_branch_calc #(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 16,
    parameter int ALIGN_W = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - IMM_W - ALIGN_W;

    logic [ADDR_W-1:0] offset;

    // Word offset to byte offset: replicate sign, append alignment zeros
    assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    assign target = base + offset;

endmodule

// File: rtl/npc_jump_calc.sv
module npc_jump_calc #(
    parameter int ADDR_W  = 32,
    parameter int TGT_W   = 26,
    parameter int ALIGN_W = 2
) (
    input  logic [ADDR_W-TGT_W-ALIGN_W-1:0] region,
    input  logic [TGT_W-1:0]                tgt,
    output logic [ADDR_W-1:0]               target
);
    // Region bits on top, word index in the middle, aligned at the bottom
    assign target = {region, tgt, {ALIGN_W{1'b0}}};

endmodule

// File: rtl/npc_source_sel.sv
module npc_source_sel
    import npc_pkg::*;
(
    input  logic     rst,
    input  logic     branch,
    input  logic     zero,
    input  logic     jump,
    output npc_src_e src
);
    // Priority: reset, then jump, then taken branch, then sequential
    always_comb begin
        if (rst) begin
            src = SRC_RESET;
        end else if (jump) begin
            src = SRC_JUMP;
        end else if (branch && zero) begin
            src = SRC_BRANCH;
        end else begin
            src = SRC_SEQ;
        end
    end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import npc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IMM_W    = 16,
    parameter int TGT_W    = 26,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic              branch_i,
    input  logic              jump_i,
    input  logic              zero_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_plus4_o
);
    localparam int ALIGN_W  = 2;
    localparam int REGION_W = ADDR_W - TGT_W - ALIGN_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t         st_d, st_q;
    npc_src_e          src;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;

    npc_seq_adder #(
        .ADDR_W (ADDR_W),
        .ALIGN_W(ALIGN_W)
    ) u_seq (
        .pc         (st_q.pc),
        .pc_next_seq(seq_addr)
    );

    npc_branch_calc #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .ALIGN_W(ALIGN_W)
    ) u_br (
        .base  (seq_addr),
        .imm   (imm_i),
        .target(br_addr)
    );

    npc_jump_calc #(
        .ADDR_W (ADDR_W),
        .TGT_W  (TGT_W),
        .ALIGN_W(ALIGN_W)
    ) u_jmp (
        .region(seq_addr[ADDR_W-1 -: REGION_W]),
        .tgt   (target_i),
        .target(jmp_addr)
    );

    npc_source_sel u_sel (
        .rst   (rst),
        .branch(branch_i),
        .zero  (zero_i),
        .jump  (jump_i),
        .src   (src)
    );

    always_comb begin
        st_d = st_q;
        unique case (src)
            SRC_RESET:  st_d.pc = RESET_PC;
            SRC_JUMP:   st_d.pc = jmp_addr;
            SRC_BRANCH: st_d.pc = br_addr;
            default:    st_d.pc = seq_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign pc_plus4_o = seq_addr;

    // R1: reset loads the reset address regardless of the select flags
    a_r1_reset_load: assert property (@(posedge clk)
        rst |=> (pc_o == RESET_PC));

    // R2: no branch and no jump gives a one-word step
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && !branch_i) |=> (pc_o == $past(pc_o) + STEP));

    // R3: the incremented output tracks the register
    a_r3_plus4_track: assert property (@(posedge clk) disable iff (rst)
        (pc_plus4_o - pc_o) == STEP);

    // R4: taken branch moves by the immediate in words from counter + 4
    a_r4_branch_offset: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && branch_i && zero_i) |=>
        ((pc_o[IMM_W+ALIGN_W-1:ALIGN_W] - $past(pc_plus4_o[IMM_W+ALIGN_W-1:ALIGN_W])) == $past(imm_i)));

    // R5: branch with zero low falls through
    a_r5_not_taken: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && branch_i && !zero_i) |=> (pc_o == $past(pc_plus4_o)));

    // R6, R7: jump takes region from counter + 4 and wins over any branch
    a_r6_r7_jump_fields: assert property (@(posedge clk) disable iff (rst)
        jump_i |=> ((pc_o[TGT_W+ALIGN_W-1:ALIGN_W] == $past(target_i)) &&
                    (pc_o[ADDR_W-1 -: REGION_W] == $past(pc_plus4_o[ADDR_W-1 -: REGION_W]))));

    // R8: word alignment is kept
    a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
        pc_o[ALIGN_W-1:0] == '0);

endmodule

// File: tb/nextpc_unit_test.sv
module nextpc_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] imm_i;
    logic [25:0] target_i;
    logic        branch_i, jump_i, zero_i;
    logic [31:0] pc_o, pc_plus4_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model_pc;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nextpc_unit uut (
        .clk(clk), .rst(rst), .imm_i(imm_i), .target_i(target_i),
        .branch_i(branch_i), .jump_i(jump_i), .zero_i(zero_i),
        .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%08h expected=%08h", req, got, exp);
        end
    endtask

    // Apply one instruction's inputs, clock once, compare with the model
    task automatic step(input string req, input logic r, input logic [15:0] im,
                        input logic [25:0] tg, input logic b, input logic j, input logic z);
        logic [31:0] nxt;
        @(negedge clk);
        rst = r; imm_i = im; target_i = tg; branch_i = b; jump_i = j; zero_i = z;
        if (r)          nxt = 32'h0;
        else if (j)     nxt = ((model_pc + 32'd4) & 32'hF000_0000) | {4'h0, tg, 2'b00};
        else if (b & z) nxt = model_pc + 32'd4 + {{14{im[15]}}, im, 2'b00};
        else            nxt = model_pc + 32'd4;
        @(posedge clk);
        #1;
        model_pc = nxt;
        chk(req, pc_o, model_pc);
        chk("R3", pc_plus4_o, model_pc + 32'd4);
        chk("R8", {30'h0, pc_o[1:0]}, 32'h0);
    endtask

    initial begin
        model_pc = 32'h0;
        rst = 1'b1; imm_i = '0; target_i = '0; branch_i = 1'b0; jump_i = 1'b0; zero_i = 1'b0;
        // R1: reset with every flag high
        step("R1", 1'b1, 16'h7FFF, 26'h3FF_FFFF, 1'b1, 1'b1, 1'b1);
        chk("R1", pc_o, 32'h0);
        // R2: sequential steps
        for (int i = 0; i < 8; i++) step("R2", 1'b0, 16'(i * 97), 26'(i), 1'b0, 1'b0, 1'b0);
        chk("R2", pc_o, 32'd32);
        // R4: forward and backward branches across the whole offset range
        for (int i = 0; i < 65536; i += 131) begin
            step("R4", 1'b0, 16'(i), 26'h0, 1'b1, 1'b0, 1'b1);
            step("R4", 1'b0, 16'(-i), 26'h0, 1'b1, 1'b0, 1'b1);
        end
        // R4: explicit backward branch by 3 words from a known point
        step("R1", 1'b1, 16'h0, 26'h0, 1'b0, 1'b0, 1'b0);
        step("R6", 1'b0, 16'h0, 26'h000_0100, 1'b0, 1'b1, 1'b0);
        step("R4", 1'b0, 16'hFFFD, 26'h0, 1'b1, 1'b0, 1'b1);
        chk("R4", pc_o, 32'h0000_0400 + 32'd4 - 32'd12);
        // R5/R7: every flag combination
        for (int k = 0; k < 8; k++)
            step((k[1]) ? "R7" : "R5", 1'b0, 16'h0040, 26'h00A_BCDE, k[0], k[1], k[2]);
        // R6: jump into last word of each region, then across the boundary
        step("R1", 1'b1, 16'h0, 26'h0, 1'b0, 1'b0, 1'b0);
        for (int r = 0; r < 16; r++) begin
            step("R6", 1'b0, 16'h0, 26'h3FF_FFFF, 1'b0, 1'b1, 1'b0);
            chk("R6", pc_o, {4'(r), 28'hFFF_FFFC});
        end
        // R9: wrap from top of address space
        step("R9", 1'b0, 16'h0, 26'h0, 1'b0, 1'b0, 1'b0);
        chk("R9", pc_o, 32'h0);
        // R6: jump at region end with target 0 enters next region
        step("R6", 1'b0, 16'h0, 26'h3FF_FFFF, 1'b0, 1'b1, 1'b0);
        step("R6", 1'b0, 16'h0, 26'h000_0000, 1'b0, 1'b1, 1'b0);
        chk("R6", pc_o, 32'h1000_0000);
        // R1: mid-run reset with a taken branch pending
        step("R1", 1'b1, 16'h0010, 26'h0, 1'b1, 1'b0, 1'b1);
        chk("R1", pc_o, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog got=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule